// File: doc/BRIEF.md
# Bus Target Burst Termination Controller

This block is the target-side handshake engine of a parallel, multiplexed bus slave. Once address decode claims a transaction, it drives the three active-low target handshake lines: device-select, target-ready and stop. It does this for every data phase of the burst. Per-phase requests from local logic steer it: a word is ready, this word is the last, the target halts without data, or a fatal error occurred. A static configuration input makes the target refuse bursts altogether.

From these requests the block produces one of five endings. The first is an ordinary transfer that the initiator ends. The others are a disconnect that carries data, a disconnect that carries no data, a retry (a dataless stop before any word has moved) and a target abort. A sticky flag records whether data has moved, and that flag separates a retry from a plain dataless disconnect. An initiator may be committed to one more data phase when it sees stop. In that case the block keeps stop asserted alone until the initiator releases its frame line. When the transaction ends, a one-cycle report gives the kind of ending.

Top module: `pci_tgt_term`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are high and `end_vld` is low.
- R2: In idle, a rising edge with `claim` high and `frame_n` low pulls `devsel_n` low after that edge. `claim` seen while `frame_n` is high is ignored, and `devsel_n` stays high.
- R3: A data phase completes on an edge where `irdy_n` is low and `trdy_n` or `stop_n` is low. Data moves only when `trdy_n` is low. A completing phase with `frame_n` high ends the transaction: after that edge all three handshake outputs are high and `end_vld` pulses for one cycle. An ending without any stop reports `end_code` 0.
- R4: When a word is ready and either `last_req` or `single_only` is high, the next phase drives `trdy_n` and `stop_n` low together and the ending reports `end_code` 1. With `single_only` high every transaction moves exactly one word.
- R5: `halt_req` after at least one word has moved gives `stop_n` low with `trdy_n` high, and the ending reports `end_code` 2.
- R6: `halt_req` before any word has moved is a retry: `stop_n` low, `trdy_n` high, no word moves, and the ending reports `end_code` 3.
- R7: `fatal_req` releases `devsel_n` at a phase start. `stop_n` then falls after exactly `ABORT_GAP` cycles with `devsel_n` high, `trdy_n` stays high, and the ending reports `end_code` 4. `fatal_req` takes priority over `halt_req`, which takes priority over `data_rdy`.
- R8: While `trdy_n` or `stop_n` is low and the phase has not completed, all three handshake outputs hold their values.
- R9: If a phase completes with `stop_n` low and `frame_n` still low, the next phase drives `stop_n` low and `trdy_n` high until a phase completes with `frame_n` high.
- R10: `trdy_n` is never low while `devsel_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator frame line, active low |
| irdy_n | input | 1 | Initiator ready line, active low |
| claim | input | 1 | Address decode hit for the transaction now starting |
| single_only | input | 1 | Static configuration: refuse bursts |
| data_rdy | input | 1 | Local side can move a word in the next phase |
| last_req | input | 1 | The next word is the final one |
| halt_req | input | 1 | Stop without moving data |
| fatal_req | input | 1 | Fatal error; abort the transaction |
| devsel_n | output | 1 | Target claim line, active low |
| trdy_n | output | 1 | Target ready line, active low |
| stop_n | output | 1 | Target stop line, active low |
| end_vld | output | 1 | One-cycle pulse when a transaction ends |
| end_code | output | 3 | Ending kind: 0 normal, 1 disconnect with data, 2 disconnect without data, 3 retry, 4 abort |

## Verification
The bench builds the block with `ABORT_GAP` set to 2 rather than the default of 1. This makes the released-select window two cycles long, so the abort check can tell a counter that stops too early from one that stops too late. The bench's initiator model can react to stop at once or one phase late. It can also insert initial wait states. Together these reach both disconnect timings and the output hold rule under an initiator that is not ready.

// File: rtl/tt_pkg.sv
package tt_pkg;

  typedef enum logic [1:0] {
    TT_IDLE = 2'd0,
    TT_ACT  = 2'd1,
    TT_ABT  = 2'd2
  } tt_state_e;

  typedef enum logic [2:0] {
    END_NORM  = 3'd0,
    END_DWD   = 3'd1,
    END_DND   = 3'd2,
    END_RETRY = 3'd3,
    END_ABORT = 3'd4
  } tt_end_e;

  // A phase retires when the initiator is ready and the target either
  // hands over a word or asks to stop.
  function automatic logic tt_phase_done(logic irdy_n, logic trdy_n, logic stop_n);
    return !irdy_n && (!trdy_n || !stop_n);
  endfunction

  // Ending reported for a dataless stop depends on whether a word moved.
  function automatic tt_end_e tt_halt_kind(logic moved);
    return moved ? END_DND : END_RETRY;
  endfunction

endpackage

// File: rtl/tt_decide.sv
module tt_decide
  import tt_pkg::*;
(
  input  logic    fatal,
  input  logic    halt,
  input  logic    ready,
  input  logic    last,
  input  logic    single,
  input  logic    moved_nx,
  output logic    rel_sel,
  output logic    nx_trdy_n,
  output logic    nx_stop_n,
  output logic    kind_we,
  output tt_end_e kind
);

  logic stop_with_word;
  assign stop_with_word = single || last;

  always_comb begin
    rel_sel   = 1'b0;
    nx_trdy_n = 1'b1;
    nx_stop_n = 1'b1;
    kind_we   = 1'b0;
    kind      = END_NORM;
    if (fatal) begin
      rel_sel = 1'b1;
      kind_we = 1'b1;
      kind    = END_ABORT;
    end else if (halt) begin
      nx_stop_n = 1'b0;
      kind_we   = 1'b1;
      kind      = tt_halt_kind(moved_nx);
    end else if (ready) begin
      nx_trdy_n = 1'b0;
      nx_stop_n = !stop_with_word;
      kind_we   = stop_with_word;
      kind      = END_DWD;
    end
  end

endmodule

// File: rtl/tt_ledger.sv
module tt_ledger
  import tt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       data_done,
  input  logic       kind_we,
  input  tt_end_e    kind_in,
  input  logic       finish,
  output logic       moved_nx,
  output logic       end_vld,
  output logic [2:0] end_code
);

  logic    moved_q;
  tt_end_e kind_q;

  assign moved_nx = moved_q || data_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moved_q  <= 1'b0;
      kind_q   <= END_NORM;
      end_vld  <= 1'b0;
      end_code <= 3'd0;
    end else begin
      end_vld <= finish;
      if (finish) end_code <= kind_q;
      if (start) begin
        moved_q <= 1'b0;
        kind_q  <= END_NORM;
      end else begin
        moved_q <= moved_nx;
        if (kind_we) kind_q <= kind_in;
      end
    end
  end

  // R6: a retry report only ever follows a transaction with no word moved
  assert_retry_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_vld && end_code == END_RETRY) |-> !moved_q);

  // R5: a dataless disconnect report only follows moved data
  assert_nodata_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_vld && end_code == END_DND) |-> moved_q);

endmodule

// File: rtl/tt_abort_gap.sv
module tt_abort_gap #(
  parameter int ABORT_GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int CW = (ABORT_GAP < 2) ? 1 : $clog2(ABORT_GAP + 1);
  localparam logic [CW-1:0] LAST = CW'(ABORT_GAP - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (run)  cnt_q <= cnt_q + 1'b1;
    else           cnt_q <= '0;
  end

  // R7: the wait window never runs past its configured length
  assert_gap_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
  import tt_pkg::*;
#(
  parameter int ABORT_GAP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       claim,
  input  logic       single_only,
  input  logic       data_rdy,
  input  logic       last_req,
  input  logic       halt_req,
  input  logic       fatal_req,
  output logic       devsel_n,
  output logic       trdy_n,
  output logic       stop_n,
  output logic       end_vld,
  output logic [2:0] end_code
);

  tt_state_e st_q;
  logic      dev_q, trdy_q, stop_q;

  // Named events shared by the datapath and the assertions
  logic    phase_done, last_done, extra_ph, decide_pt, waiting, accept;
  logic    gap_done, moved_nx;
  logic    rel_sel, nx_trdy_n, nx_stop_n, kind_we;
  tt_end_e kind;

  assign phase_done = (st_q != TT_IDLE) && tt_phase_done(irdy_n, trdy_q, stop_q);
  assign last_done  = phase_done && frame_n;
  assign extra_ph   = phase_done && !frame_n && !stop_q;
  assign decide_pt  = (st_q == TT_ACT) && !last_done && !extra_ph &&
                      (phase_done || (trdy_q && stop_q));
  assign waiting    = (st_q == TT_ACT) && !phase_done && !(trdy_q && stop_q);
  assign accept     = (st_q == TT_IDLE) && claim && !frame_n;

  tt_decide u_decide (
    .fatal     (fatal_req),
    .halt      (halt_req),
    .ready     (data_rdy),
    .last      (last_req),
    .single    (single_only),
    .moved_nx  (moved_nx),
    .rel_sel   (rel_sel),
    .nx_trdy_n (nx_trdy_n),
    .nx_stop_n (nx_stop_n),
    .kind_we   (kind_we),
    .kind      (kind)
  );

  tt_ledger u_ledger (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .data_done (phase_done && !trdy_q),
    .kind_we   (decide_pt && kind_we),
    .kind_in   (kind),
    .finish    (last_done),
    .moved_nx  (moved_nx),
    .end_vld   (end_vld),
    .end_code  (end_code)
  );

  tt_abort_gap #(.ABORT_GAP(ABORT_GAP)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == TT_ABT),
    .done  (gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TT_IDLE;
      dev_q  <= 1'b1;
      trdy_q <= 1'b1;
      stop_q <= 1'b1;
    end else begin
      case (st_q)
        TT_IDLE: begin
          if (accept) begin
            dev_q <= 1'b0;
            st_q  <= TT_ACT;
          end
        end
        TT_ACT: begin
          if (last_done) begin
            dev_q  <= 1'b1;
            trdy_q <= 1'b1;
            stop_q <= 1'b1;
            st_q   <= TT_IDLE;
          end else if (extra_ph) begin
            trdy_q <= 1'b1;
            stop_q <= 1'b0;
          end else if (decide_pt) begin
            if (rel_sel) begin
              dev_q  <= 1'b1;
              trdy_q <= 1'b1;
              stop_q <= 1'b1;
              st_q   <= TT_ABT;
            end else begin
              trdy_q <= nx_trdy_n;
              stop_q <= nx_stop_n;
            end
          end
        end
        TT_ABT: begin
          if (gap_done) begin
            stop_q <= 1'b0;
            st_q   <= TT_ACT;
          end
        end
        default: st_q <= TT_IDLE;
      endcase
    end
  end

  assign devsel_n = dev_q;
  assign trdy_n   = trdy_q;
  assign stop_n   = stop_q;

  // R8: a pending handshake freezes all three lines
  assert_hold_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> ($stable(devsel_n) && $stable(trdy_n) && $stable(stop_n)));

  // R10: no word is offered without the claim line
  assert_trdy_claimed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  // R7: stop under a released claim line follows a released claim line
  assert_abort_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_n) && devsel_n) |-> ($past(devsel_n) && trdy_n));

  // R9: a committed initiator gets a stop-only phase
  assert_extra_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    extra_ph |=> (!stop_n && trdy_n));

  // R3: the closing phase returns every line high and reports once
  assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> (devsel_n && trdy_n && stop_n && end_vld));

  // R4: with bursts refused, every offered word carries stop
  assert_single_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (single_only && $stable(single_only) && $fell(trdy_n)) |-> !stop_n);

endmodule

// File: tb/test_pci_tgt_term.sv
module test_pci_tgt_term;

  localparam int CLK_P = 10;
  localparam int GAP   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1, irdy_n = 1'b1, claim = 1'b0, single_only = 1'b0;
  logic       data_rdy = 1'b0, last_req = 1'b0, halt_req = 1'b0, fatal_req = 1'b0;
  logic       devsel_n, trdy_n, stop_n, end_vld;
  logic [2:0] end_code;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pci_tgt_term #(.ABORT_GAP(GAP)) i_pci_tgt_term (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .claim(claim),
    .single_only(single_only), .data_rdy(data_rdy), .last_req(last_req),
    .halt_req(halt_req), .fatal_req(fatal_req), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n), .end_vld(end_vld), .end_code(end_code)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string code_req(input int code);
    case (code)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Monitor: pops the expected ending for every report the design makes
  always @(negedge clk) begin
    if (rst_n && end_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected end report", int'(end_code), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(end_code) == e, code_req(e), "end_code", int'(end_code), e);
      end
    end
  end

  // Driver: one transaction. Requests keyed to words moved so far (-1 = never).
  task automatic run_txn(input int want, input bit late, input int halt_k,
                         input int last_k, input int fatal_k, input bit single,
                         input int iwait, input int exp_code, input int exp_words);
    int  words = 0;
    int  stop_seen = 0;
    int  dev_hi_run = 0;
    bit  prev_pend = 1'b0, prev_data = 1'b0, prev_frame = 1'b0, prev_stop = 1'b0;
    bit  prev_wait = 1'b0;
    logic pd, pt, ps;
    bit  done = 1'b0;
    exp_q.push_back(exp_code);
    @(negedge clk);
    single_only = single;
    claim = 1'b1; frame_n = 1'b0; irdy_n = 1'b1;
    pd = 1'b1; pt = 1'b1; ps = 1'b1;
    for (int c = 1; c < 200 && !done; c++) begin
      @(negedge clk);
      claim = 1'b0;
      if (c == 1) chk(devsel_n == 1'b0, "R2", "devsel after claim", devsel_n, 0);
      if (prev_pend) begin
        if (prev_data) words++;
        if (prev_frame) done = 1'b1;
      end
      if (done) begin
        chk(devsel_n && trdy_n && stop_n, "R3", "lines high after end",
            {devsel_n, trdy_n, stop_n}, 7);
        chk(words == exp_words, code_req(exp_code), "words moved", words, exp_words);
        if (single) chk(words == 1, "R4", "single word", words, 1);
        break;
      end
      // pin-level rules
      if (!trdy_n) chk(!devsel_n, "R10", "trdy with devsel released", devsel_n, 0);
      if (prev_wait)
        chk(devsel_n == pd && trdy_n == pt && stop_n == ps, "R8", "hold while waiting",
            {devsel_n, trdy_n, stop_n}, {pd, pt, ps});
      if (prev_pend && prev_stop && !prev_frame)
        chk(!stop_n && trdy_n, "R9", "stop-only extra phase", {trdy_n, stop_n}, 2);
      if (!stop_n && stop_seen == 0) begin
        if (exp_code == 4) begin
          chk(devsel_n == 1'b1 && dev_hi_run == GAP, "R7", "devsel released cycles",
              dev_hi_run, GAP);
          chk(trdy_n, "R7", "trdy high on abort", trdy_n, 1);
        end
        if (exp_code == 2 || exp_code == 3)
          chk(trdy_n, code_req(exp_code), "trdy high on dataless stop", trdy_n, 1);
        if (exp_code == 1)
          chk(!trdy_n, "R4", "trdy with stop", trdy_n, 0);
      end
      dev_hi_run = devsel_n ? dev_hi_run + 1 : 0;
      // initiator
      irdy_n = (c <= iwait);
      if (words == want - 1) frame_n = 1'b1;
      if (!stop_n) begin
        if (!late || stop_seen > 0) frame_n = 1'b1;
        stop_seen++;
      end
      // local side
      begin
        bit pend;
        int wc;
        pend = !irdy_n && (!trdy_n || !stop_n);
        wc = words + ((pend && !trdy_n) ? 1 : 0);
        data_rdy  = 1'b1;
        halt_req  = (halt_k >= 0) && (wc >= halt_k);
        last_req  = (last_k >= 1) && (wc >= last_k - 1);
        fatal_req = (fatal_k >= 0) && (wc >= fatal_k);
        prev_pend  = pend;
        prev_data  = pend && !trdy_n;
        prev_stop  = !stop_n;
        prev_frame = frame_n;
        prev_wait  = !pend && (!trdy_n || !stop_n);
        pd = devsel_n; pt = trdy_n; ps = stop_n;
      end
    end
    chk(done, code_req(exp_code), "transaction ended", done, 1);
    frame_n = 1'b1; irdy_n = 1'b1;
    data_rdy = 1'b0; halt_req = 1'b0; last_req = 1'b0; fatal_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n, "R1", "lines in reset", {devsel_n, trdy_n, stop_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !end_vld, "R1", "lines after reset",
        {devsel_n, trdy_n, stop_n, end_vld}, 14);

    // R2: claim with frame high is ignored
    claim = 1'b1; frame_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(devsel_n == 1'b1, "R2", "claim ignored without frame", devsel_n, 1);
    claim = 1'b0;
    @(negedge clk);

    //      want late halt last fatal single iwait code words
    run_txn(3,   0,   -1,  0,   -1,   0,     0,    0,   3);  // R3 normal burst
    run_txn(4,   0,   -1,  0,   -1,   1,     0,    1,   1);  // R4 single, immediate
    run_txn(4,   1,   -1,  0,   -1,   1,     0,    1,   1);  // R4/R9 single, late
    run_txn(5,   0,   -1,  2,   -1,   0,     0,    1,   2);  // R4 last word
    run_txn(5,   1,    2,  0,   -1,   0,     0,    2,   2);  // R5/R9 dataless, late
    run_txn(3,   0,    0,  0,   -1,   0,     0,    3,   0);  // R6 retry
    run_txn(3,   1,    0,  0,   -1,   0,     0,    3,   0);  // R6/R9 retry, late
    run_txn(4,   0,   -1,  0,    1,   0,     0,    4,   1);  // R7 abort after a word
    run_txn(4,   0,    0,  0,    0,   0,     0,    4,   0);  // R7 fatal beats halt
    run_txn(2,   0,   -1,  0,   -1,   0,     3,    0,   2);  // R8 initiator waits
    run_txn(1,   0,   -1,  0,   -1,   1,     0,    1,   1);  // R4 initiator ends with stop

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all endings reported", exp_q.size(), 0);
    finish_run();
  end

endmodule